// File: doc/BRIEF.md
# Dual-Port Token Semaphore Bank

This block holds eight independent one-bit token semaphores shared by two ports, called left and right. Either port claims a token by writing 0 to a flag and gives it back by writing 1. A port reads a flag to learn whether it holds the token. A claim made while the other port holds the token is not lost. It stays pending inside the flag and turns into ownership when the holder gives the token back. The claiming port may withdraw it at any time before that.

Each port has the control set of a shared-memory port. A port reaches semaphore space when its chip enable (active low) is high and its semaphore select (active low) is low. The write strobe picks a write or a read. The low three address bits pick the flag. The block is fully synchronous. A read returns its answer in the cycle after the access, marked by a one-cycle valid strobe, and that strobe cannot be held off. A read sees the flag state from before any write made in the same cycle.

Top module: `sem_unit`

## Requirements
- R1: A synchronous reset makes all eight flags free. In the first cycle after reset both read-valid strobes are low.
- R2: A port performs a semaphore access only when its chip enable input is 1 and its semaphore select input is 0. Any other combination leaves every flag unchanged and raises no read-valid strobe.
- R3: Address bits 2..0 select the flag. The higher address bits have no effect.
- R4: A write (write strobe 1) uses only data bit 0. The value 0 requests the token and the value 1 releases it or withdraws a pending request. Data bits 15..1 are ignored.
- R5: A read (write strobe 0) raises that port's read-valid strobe for exactly the following cycle. The read data then holds the flag value copied onto all 16 bits: 16'h0000 if the reading port owns the token, 16'hFFFF otherwise. The value is taken from the state before that cycle's writes.
- R6: A request to a free flag makes the requester the owner at once. A free flag reads 16'hFFFF from both ports, and the two ports never both read 0 from the same flag.
- R7: A request made while the other port owns the flag becomes pending. When the owner releases, the pending port becomes the owner.
- R8: A port that has a pending request cancels it by writing 1 before the owner releases. The owner then keeps the token, and a later release by the owner leaves the flag free.
- R9: When both ports request the same free flag in the same cycle, the left port becomes the owner and the right port's request becomes pending.
- R10: A request from the current owner, and a release from a port that neither owns the flag nor has a request pending on it, leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_ce_n | input | 1 | Left chip enable, active low; must be 1 for a semaphore access |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_wr | input | 1 | Left write strobe (1 write, 0 read) |
| l_addr | input | 12 | Left address; bits 2..0 select the flag |
| l_wdata | input | 16 | Left write data; bit 0 used |
| l_rvalid | output | 1 | Left read result valid |
| l_rdata | output | 16 | Left read result, replicated flag value |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_wr | input | 1 | Right write strobe |
| r_addr | input | 12 | Right address |
| r_wdata | input | 16 | Right write data |
| r_rvalid | output | 1 | Right read result valid |
| r_rdata | output | 16 | Right read result |

## Verification
A write changes the flag state at the clock edge that samples it. A read's result and its valid strobe appear after that same edge, one cycle after the access is presented. The bench drives each access on a falling edge and updates its own flag model at the next rising edge. It then compares both ports' strobe and data on the following falling edge. The expected read value comes from the model state before the update, which matches the rule that a read ignores writes made in the same cycle.

// File: rtl/sem_unit_pkg.sv
package sem_unit_pkg;
  typedef enum logic [2:0] {
    TOK_FREE    = 3'd0,
    TOK_LEFT    = 3'd1,
    TOK_RIGHT   = 3'd2,
    TOK_LEFT_RW = 3'd3,
    TOK_RIGHT_LW = 3'd4
  } tok_state_e;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int FLAGS  = 8,
  localparam int SEL_W = $clog2(FLAGS)
) (
  input  logic              ce_n,
  input  logic              sem_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [FLAGS-1:0]  req,
  output logic [FLAGS-1:0]  rel,
  output logic              rd_en,
  output logic [SEL_W-1:0]  rd_sel
);
  logic access;
  logic unused_bits;

  assign access = ce_n & ~sem_n;
  assign rd_en  = access & ~wr;
  assign rd_sel = addr[SEL_W-1:0];
  assign unused_bits = ^{addr[ADDR_W-1:SEL_W], wdata[DATA_W-1:1]};

  for (genvar i = 0; i < FLAGS; i++) begin : g_dec
    logic hit;
    assign hit    = access & wr & (addr[SEL_W-1:0] == SEL_W'(i));
    assign req[i] = hit & ~wdata[0];
    assign rel[i] = hit &  wdata[0];
  end
endmodule

// File: rtl/sem_flag.sv
module sem_flag
  import sem_unit_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic l_req,
  input  logic l_rel,
  input  logic r_req,
  input  logic r_rel,
  output logic l_own,
  output logic r_own
);
  tok_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      TOK_FREE:
        if (l_req)      st_nx = r_req ? TOK_LEFT_RW : TOK_LEFT;
        else if (r_req) st_nx = TOK_RIGHT;
      TOK_LEFT:
        if (l_rel)      st_nx = r_req ? TOK_RIGHT : TOK_FREE;
        else if (r_req) st_nx = TOK_LEFT_RW;
      TOK_RIGHT:
        if (r_rel)      st_nx = l_req ? TOK_LEFT : TOK_FREE;
        else if (l_req) st_nx = TOK_RIGHT_LW;
      TOK_LEFT_RW:
        if (l_rel)      st_nx = r_rel ? TOK_FREE : TOK_RIGHT;
        else if (r_rel) st_nx = TOK_LEFT;
      TOK_RIGHT_LW:
        if (r_rel)      st_nx = l_rel ? TOK_FREE : TOK_LEFT;
        else if (l_rel) st_nx = TOK_RIGHT;
      default:          st_nx = TOK_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= TOK_FREE;
    else     st <= st_nx;
  end

  assign l_own = (st == TOK_LEFT)  || (st == TOK_LEFT_RW);
  assign r_own = (st == TOK_RIGHT) || (st == TOK_RIGHT_LW);
endmodule

// File: rtl/sem_readout.sv
module sem_readout #(
  parameter int DATA_W = 16,
  parameter int FLAGS  = 8,
  localparam int SEL_W = $clog2(FLAGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [FLAGS-1:0]  own,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '1;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= {DATA_W{~own[rd_sel]}};
    end
  end
endmodule

// File: rtl/sem_unit.sv
module sem_unit #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int FLAGS  = 8,
  localparam int SEL_W = $clog2(FLAGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_ce_n,
  input  logic              l_sem_n,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic              l_rvalid,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_ce_n,
  input  logic              r_sem_n,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic              r_rvalid,
  output logic [DATA_W-1:0] r_rdata
);
  logic [FLAGS-1:0] l_req, l_rel, r_req, r_rel;
  logic [FLAGS-1:0] l_own_v, r_own_v;
  logic             l_rd, r_rd;
  logic [SEL_W-1:0] l_sel, r_sel;

  sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAGS(FLAGS)) u_dec_l (
    .ce_n(l_ce_n), .sem_n(l_sem_n), .wr(l_wr), .addr(l_addr), .wdata(l_wdata),
    .req(l_req), .rel(l_rel), .rd_en(l_rd), .rd_sel(l_sel));

  sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAGS(FLAGS)) u_dec_r (
    .ce_n(r_ce_n), .sem_n(r_sem_n), .wr(r_wr), .addr(r_addr), .wdata(r_wdata),
    .req(r_req), .rel(r_rel), .rd_en(r_rd), .rd_sel(r_sel));

  for (genvar i = 0; i < FLAGS; i++) begin : g_flag
    sem_flag u_flag (
      .clk(clk), .rst(rst),
      .l_req(l_req[i]), .l_rel(l_rel[i]),
      .r_req(r_req[i]), .r_rel(r_rel[i]),
      .l_own(l_own_v[i]), .r_own(r_own_v[i]));
  end

  sem_readout #(.DATA_W(DATA_W), .FLAGS(FLAGS)) u_rd_l (
    .clk(clk), .rst(rst), .rd_en(l_rd), .rd_sel(l_sel), .own(l_own_v),
    .rvalid(l_rvalid), .rdata(l_rdata));

  sem_readout #(.DATA_W(DATA_W), .FLAGS(FLAGS)) u_rd_r (
    .clk(clk), .rst(rst), .rd_en(r_rd), .rd_sel(r_sel), .own(r_own_v),
    .rvalid(r_rvalid), .rdata(r_rdata));
endmodule

// File: rtl/sem_unit_chk.sv
module sem_unit_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int FLAGS  = 8,
  localparam int SEL_W = $clog2(FLAGS)
) (
  input logic              clk,
  input logic              rst,
  input logic              l_ce_n,
  input logic              l_sem_n,
  input logic              l_wr,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_wdata,
  input logic              l_rvalid,
  input logic [DATA_W-1:0] l_rdata,
  input logic              r_ce_n,
  input logic              r_sem_n,
  input logic              r_wr,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_rvalid,
  input logic [DATA_W-1:0] r_rdata,
  input logic [FLAGS-1:0]  l_own_v,
  input logic [FLAGS-1:0]  r_own_v
);
  logic l_acc, r_acc;
  logic [SEL_W-1:0] l_a, r_a;
  assign l_acc = l_ce_n && !l_sem_n;
  assign r_acc = r_ce_n && !r_sem_n;
  assign l_a   = l_addr[SEL_W-1:0];
  assign r_a   = r_addr[SEL_W-1:0];

  assert_rst_quiet_R1: assert property (@(posedge clk)
    rst |=> (!l_rvalid && !r_rvalid));

  assert_no_access_R2: assert property (@(posedge clk) disable iff (rst)
    !l_acc |=> !l_rvalid);

  assert_replicated_R5: assert property (@(posedge clk) disable iff (rst)
    l_rvalid |-> (l_rdata == '0 || l_rdata == '1));

  assert_single_owner_R6: assert property (@(posedge clk) disable iff (rst)
    (l_acc && !l_wr && r_acc && !r_wr && l_a == r_a)
      |=> !(l_rdata[0] == 1'b0 && r_rdata[0] == 1'b0));

  assert_free_grant_R6: assert property (@(posedge clk) disable iff (rst)
    (l_acc && l_wr && !l_wdata[0] && !r_own_v[l_a]) |=> l_own_v[$past(l_a)]);

  assert_release_R4: assert property (@(posedge clk) disable iff (rst)
    (l_acc && l_wr && l_wdata[0]) |=> !l_own_v[$past(l_a)]);
endmodule

bind sem_unit sem_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAGS(FLAGS)) u_chk (
  .clk(clk), .rst(rst),
  .l_ce_n(l_ce_n), .l_sem_n(l_sem_n), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata),
  .l_rvalid(l_rvalid), .l_rdata(l_rdata),
  .r_ce_n(r_ce_n), .r_sem_n(r_sem_n), .r_wr(r_wr), .r_addr(r_addr),
  .r_rvalid(r_rvalid), .r_rdata(r_rdata),
  .l_own_v(l_own_v), .r_own_v(r_own_v));

// File: tb/sim_sem_unit.sv
module sim_sem_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_ce_n = 1'b0, l_sem_n = 1'b1, l_wr = 1'b0;
  logic r_ce_n = 1'b0, r_sem_n = 1'b1, r_wr = 1'b0;
  logic [11:0] l_addr = '0, r_addr = '0;
  logic [15:0] l_wdata = '0, r_wdata = '0;
  logic        l_rvalid, r_rvalid;
  logic [15:0] l_rdata, r_rdata;

  int checks = 0;
  int errors = 0;
  int model [8];

  always #10 clk = ~clk;

  sem_unit u0 (.*);

  // bench flag model: 0 free, 1 left, 2 right, 3 left+right waiting, 4 right+left waiting
  function automatic int step_flag(int s, bit lq, bit ll, bit rq, bit rl);
    case (s)
      0: return lq ? (rq ? 3 : 1) : (rq ? 2 : 0);
      1: return ll ? (rq ? 2 : 0) : (rq ? 3 : 1);
      2: return rl ? (lq ? 1 : 0) : (lq ? 4 : 2);
      3: return ll ? (rl ? 0 : 2) : (rl ? 1 : 3);
      4: return rl ? (ll ? 0 : 1) : (ll ? 2 : 4);
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] read_val(int s, bit left);
    bit own = left ? (s == 1 || s == 3) : (s == 2 || s == 4);
    return own ? 16'h0000 : 16'hFFFF;
  endfunction

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle on both ports; called at a falling edge
  task automatic cyc(input bit lce, lsem, lwr, input logic [11:0] la, input logic [15:0] ld,
                     input bit rce, rsem, rwr, input logic [11:0] ra, input logic [15:0] rd,
                     input string tag);
    bit lacc = lce && !lsem;
    bit racc = rce && !rsem;
    bit lrd = lacc && !lwr;
    bit rrd = racc && !rwr;
    logic [15:0] le = read_val(model[la[2:0]], 1'b1);
    logic [15:0] re = read_val(model[ra[2:0]], 1'b0);
    l_ce_n = lce; l_sem_n = lsem; l_wr = lwr; l_addr = la; l_wdata = ld;
    r_ce_n = rce; r_sem_n = rsem; r_wr = rwr; r_addr = ra; r_wdata = rd;
    @(posedge clk);
    for (int f = 0; f < 8; f++)
      model[f] = step_flag(model[f],
        lacc && lwr && la[2:0] == f && !ld[0], lacc && lwr && la[2:0] == f && ld[0],
        racc && rwr && ra[2:0] == f && !rd[0], racc && rwr && ra[2:0] == f && rd[0]);
    @(negedge clk);
    chk(l_rvalid == lrd, {tag, " R5 left valid"}, 16'(l_rvalid), 16'(lrd));
    chk(r_rvalid == rrd, {tag, " R5 right valid"}, 16'(r_rvalid), 16'(rrd));
    if (lrd) chk(l_rdata == le, {tag, " left data"}, l_rdata, le);
    if (rrd) chk(r_rdata == re, {tag, " right data"}, r_rdata, re);
  endtask

  task automatic idle();
    cyc(0, 1, 0, 0, 0, 0, 1, 0, 0, 0, "idle");
  endtask
  task automatic lw(logic [11:0] a, logic [15:0] d, string t);
    cyc(1, 0, 1, a, d, 0, 1, 0, 0, 0, t);
  endtask
  task automatic rw(logic [11:0] a, logic [15:0] d, string t);
    cyc(0, 1, 0, 0, 0, 1, 0, 1, a, d, t);
  endtask
  task automatic both_rd(logic [11:0] a, string t);
    cyc(1, 0, 0, a, 0, 1, 0, 0, a, 0, t);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int f = 0; f < 8; f++) model[f] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!l_rvalid && !r_rvalid, "R1 valid low after reset", 16'(l_rvalid | r_rvalid), 0);
    for (int f = 0; f < 8; f++) both_rd(12'(f), "R1 free after reset");

    // R6 free grant, single owner
    lw(12'h003, 16'h0000, "R6 request");
    both_rd(12'h003, "R6 owner reads 0, other 1");
    // R10 owner re-request, right stray release
    lw(12'h003, 16'hFFFE, "R10 owner re-request");
    rw(12'h003, 16'h0001, "R10 stray release");
    both_rd(12'h003, "R10 unchanged");
    // R7 pending then grant on release
    rw(12'h003, 16'h0000, "R7 right request pending");
    both_rd(12'h003, "R7 still left");
    lw(12'h003, 16'h0001, "R7 left release");
    both_rd(12'h003, "R7 right granted");
    // R8 withdraw
    lw(12'h003, 16'h0000, "R8 left request pending");
    lw(12'h003, 16'h0001, "R8 left withdraw");
    rw(12'h003, 16'h0001, "R8 right release");
    both_rd(12'h003, "R8 flag free");
    // R9 tie
    cyc(1, 0, 1, 12'h005, 0, 1, 0, 1, 12'h005, 0, "R9 tie");
    both_rd(12'h005, "R9 left wins");
    lw(12'h005, 16'h0001, "R9 left release");
    both_rd(12'h005, "R9 right pending granted");
    rw(12'h005, 16'h0001, "R9 right free");
    // R3 high address bits ignored
    lw(12'hFF1, 16'h0000, "R3 request via high addr");
    both_rd(12'h001, "R3 flag 1 owned");
    both_rd(12'hA09, "R3 alias read");
    lw(12'h7F1, 16'h0001, "R3 release via other alias");
    both_rd(12'h001, "R3 freed");
    // R2 wrong selects ignored
    cyc(0, 0, 1, 12'h002, 0, 1, 1, 1, 12'h002, 0, "R2 no access writes");
    cyc(0, 0, 0, 12'h002, 0, 1, 1, 0, 12'h002, 0, "R2 no access reads");
    both_rd(12'h002, "R2 flag 2 still free");
    // R4 upper data bits ignored
    rw(12'h006, 16'h8000, "R4 bit0=0 request");
    both_rd(12'h006, "R4 right owns");
    rw(12'h006, 16'h7FFF, "R4 bit0=1 release");
    both_rd(12'h006, "R4 freed");
    // R5 read sees pre-write state
    cyc(1, 0, 0, 12'h004, 0, 1, 0, 1, 12'h004, 0, "R5 read during right request");
    both_rd(12'h004, "R5 right now owns");
    idle();

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      bit lce = ($urandom_range(0, 9) != 0);
      bit lsem = ($urandom_range(0, 9) == 0);
      bit rce = ($urandom_range(0, 9) != 0);
      bit rsem = ($urandom_range(0, 9) == 0);
      logic [11:0] la = {9'($urandom), 3'($urandom_range(0, 3))};
      logic [11:0] ra = {9'($urandom), 3'($urandom_range(0, 3))};
      cyc(lce, lsem, 1'($urandom), la, 16'($urandom),
          rce, rsem, 1'($urandom), ra, 16'($urandom), "R6 R7 R8 R10 random");
    end
    for (int f = 0; f < 8; f++) both_rd(12'(f), "R6 final sweep");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule